// File: doc/BRIEF.md
# Three-Operand Modular Signed-Digit Adder

This block adds three numbers held in radix-2 signed-digit form and returns their sum as a signed-digit residue modulo either 2^P-1 or 2^P+1. A parameter picks the modulus when the block is elaborated. Every operand and the result have P digits, and each digit takes one of the values -1, 0 or +1. The block is purely combinational. It is meant as the accumulation element inside modular multipliers, where partial products arrive three at a time.

The sum is reduced in two stages. First, a carry-save stage turns the three digit vectors into two: a vector of interim digits and a vector of transfer digits. Second, a two-operand signed-digit adder chooses each interim digit and transfer by looking at the position just below it. This choice ensures that no digit goes outside {-1,0,1}, so carries never travel more than one position. In both stages the transfer that leaves the top digit comes back in at digit 0. Modulo 2^P-1 it keeps its sign. Modulo 2^P+1 its sign is inverted. Because every result digit depends on only a fixed neighbourhood of input digits, the logic depth does not grow with P.

Top module: `sd3_mod_adder`

## Requirements
- R1: With MOD_PLUS = 0, the integer value of `sum_o` is congruent to the sum of the values of `op_a`, `op_b` and `op_c` modulo 2^P-1.
- R2: With MOD_PLUS = 1, the integer value of `sum_o` is congruent to the sum of the values of `op_a`, `op_b` and `op_c` modulo 2^P+1.
- R3: Digit i of each vector occupies bits [2i+1:2i], with bit 2i+1 as the positive flag and bit 2i as the negative flag. Code 2'b10 means +1, 2'b01 means -1 and 2'b00 means 0. No digit of `sum_o` ever carries the code 2'b11.
- R4: When all three operands are zero, every digit of `sum_o` is 2'b00.
- R5: With MOD_PLUS = 0, a transfer out of digit P-1 re-enters digit 0 with the same sign. This is exercised by operands whose only nonzero digits are at position P-1.
- R6: With MOD_PLUS = 1, a transfer out of digit P-1 re-enters digit 0 with the opposite sign. This is exercised with the same kind of top-digit operands.
- R7: The residue stays correct for extreme operands: every digit +1, every digit -1, and mixtures of the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2*P | First signed-digit operand |
| op_b | input | 2*P | Second signed-digit operand |
| op_c | input | 2*P | Third signed-digit operand |
| sum_o | output | 2*P | Signed-digit residue of op_a+op_b+op_c |

## Verification
The hardest case to reach is a top-position transfer that wraps into digit 0 while digit 0 is already saturated in the same direction. The neighbour selection at position 0 has to look at digit P-1 instead of a lower digit, and for the 2^P+1 modulus it must also invert that decision. Random digits alone seldom line up all three operands at the top. The stimulus therefore adds directed vectors whose only nonzero digits sit at position P-1, and vectors of all +1 or all -1 digits, which force transfers in every position at once. Both modulus variants receive the same stimulus side by side.

// File: rtl/sd3_pkg.sv
package sd3_pkg;

   typedef struct packed {
      logic pos;
      logic neg;
   } sdig_t;

   function automatic logic signed [2:0] dval(sdig_t d);
      return $signed({2'b00, d.pos}) - $signed({2'b00, d.neg});
   endfunction

   function automatic sdig_t denc(logic signed [2:0] v);
      sdig_t r;
      r.pos = (v > 3'sd0);
      r.neg = (v < 3'sd0);
      return r;
   endfunction

   function automatic sdig_t dneg(sdig_t d);
      sdig_t r;
      r.pos = d.neg;
      r.neg = d.pos;
      return r;
   endfunction

endpackage

// File: rtl/sd3_csa.sv
module sd3_csa
   import sd3_pkg::*;
#(
   parameter int P        = 16,
   parameter bit MOD_PLUS = 1'b0
) (
   input  logic [2*P-1:0] a_i,
   input  logic [2*P-1:0] b_i,
   input  logic [2*P-1:0] c_i,
   output logic [2*P-1:0] u_o,
   output logic [2*P-1:0] t_o
);

   sdig_t t_raw [P];

   for (genvar i = 0; i < P; i++) begin : g_col
      logic signed [2:0] s;
      sdig_t tt, uu;
      always_comb begin
         s = dval(sdig_t'(a_i[2*i +: 2])) + dval(sdig_t'(b_i[2*i +: 2]))
           + dval(sdig_t'(c_i[2*i +: 2]));
         case (s)
            3'sd3:   begin tt = denc(3'sd1);  uu = denc(3'sd1);  end
            3'sd2:   begin tt = denc(3'sd1);  uu = denc(3'sd0);  end
            -3'sd2:  begin tt = denc(-3'sd1); uu = denc(3'sd0);  end
            -3'sd3:  begin tt = denc(-3'sd1); uu = denc(-3'sd1); end
            default: begin tt = denc(3'sd0);  uu = denc(s);      end
         endcase
      end
      assign t_raw[i]       = tt;
      assign u_o[2*i +: 2]  = uu;
      if (i > 0) begin : g_shift
         assign t_o[2*i +: 2] = t_raw[i-1];
      end
   end

   if (MOD_PLUS) begin : g_wrap_inv
      assign t_o[1:0] = dneg(t_raw[P-1]);
   end else begin : g_wrap_same
      assign t_o[1:0] = t_raw[P-1];
   end

   if (P <= 30) begin : g_chk
      localparam longint MODV = MOD_PLUS ? ((longint'(1) << P) + 1) : ((longint'(1) << P) - 1);
      longint vin, vout;
      always_comb begin
         vin  = 0;
         vout = 0;
         for (int k = 0; k < P; k++) begin
            vin  += (longint'(dval(sdig_t'(a_i[2*k +: 2]))) + longint'(dval(sdig_t'(b_i[2*k +: 2])))
                   + longint'(dval(sdig_t'(c_i[2*k +: 2])))) <<< k;
            vout += (longint'(dval(sdig_t'(u_o[2*k +: 2]))) + longint'(dval(sdig_t'(t_o[2*k +: 2])))) <<< k;
         end
         if (!$isunknown({a_i, b_i, c_i}))
            a_r1_csa_residue: assert (((vin - vout) % MODV) == 0)
               else $error("carry-save stage changed the residue");
      end
   end

endmodule

// File: rtl/sd3_mod_add2.sv
module sd3_mod_add2
   import sd3_pkg::*;
#(
   parameter int P        = 16,
   parameter bit MOD_PLUS = 1'b0
) (
   input  logic [2*P-1:0] x_i,
   input  logic [2*P-1:0] y_i,
   output logic [2*P-1:0] s_o
);

   sdig_t c_out [P];
   sdig_t c_in  [P];
   sdig_t w     [P];
   logic  low_nn [P];

   for (genvar i = 0; i < P; i++) begin : g_pos
      sdig_t xd, yd;
      assign xd = sdig_t'(x_i[2*i +: 2]);
      assign yd = sdig_t'(y_i[2*i +: 2]);

      if (i > 0) begin : g_nb
         assign low_nn[i] = !x_i[2*(i-1)] && !y_i[2*(i-1)];
      end else if (MOD_PLUS) begin : g_nb_inv
         assign low_nn[i] = !x_i[2*(P-1)+1] && !y_i[2*(P-1)+1];
      end else begin : g_nb_same
         assign low_nn[i] = !x_i[2*(P-1)] && !y_i[2*(P-1)];
      end

      logic signed [2:0] z;
      sdig_t cc, ww;
      always_comb begin
         z = dval(xd) + dval(yd);
         case (z)
            3'sd2:   begin cc = denc(3'sd1);  ww = denc(3'sd0); end
            -3'sd2:  begin cc = denc(-3'sd1); ww = denc(3'sd0); end
            3'sd1:   begin
               if (low_nn[i]) begin cc = denc(3'sd1); ww = denc(-3'sd1); end
               else           begin cc = denc(3'sd0); ww = denc(3'sd1);  end
            end
            -3'sd1:  begin
               if (low_nn[i]) begin cc = denc(3'sd0);  ww = denc(-3'sd1); end
               else           begin cc = denc(-3'sd1); ww = denc(3'sd1);  end
            end
            default: begin cc = denc(3'sd0); ww = denc(3'sd0); end
         endcase
      end
      assign c_out[i] = cc;
      assign w[i]     = ww;

      if (i > 0) begin : g_cin
         assign c_in[i] = c_out[i-1];
      end else if (MOD_PLUS) begin : g_cin_inv
         assign c_in[i] = dneg(c_out[P-1]);
      end else begin : g_cin_same
         assign c_in[i] = c_out[P-1];
      end

      assign s_o[2*i +: 2] = denc(dval(w[i]) + dval(c_in[i]));

      always_comb begin
         if (!$isunknown({x_i, y_i}))
            a_r3_no_overflow: assert (!(w[i].pos && c_in[i].pos) && !(w[i].neg && c_in[i].neg))
               else $error("digit %0d interim and transfer overflow", i);
      end
   end

   if (P <= 30) begin : g_chk
      localparam longint MODV = MOD_PLUS ? ((longint'(1) << P) + 1) : ((longint'(1) << P) - 1);
      longint vin, vout;
      always_comb begin
         vin  = 0;
         vout = 0;
         for (int k = 0; k < P; k++) begin
            vin  += (longint'(dval(sdig_t'(x_i[2*k +: 2]))) + longint'(dval(sdig_t'(y_i[2*k +: 2])))) <<< k;
            vout += longint'(dval(sdig_t'(s_o[2*k +: 2]))) <<< k;
         end
         if (!$isunknown({x_i, y_i}))
            a_r2_add2_residue: assert (((vin - vout) % MODV) == 0)
               else $error("two-operand stage changed the residue");
      end
   end

endmodule

// File: rtl/sd3_mod_adder.sv
module sd3_mod_adder
   import sd3_pkg::*;
#(
   parameter int P        = 16,
   parameter bit MOD_PLUS = 1'b0
) (
   input  logic [2*P-1:0] op_a,
   input  logic [2*P-1:0] op_b,
   input  logic [2*P-1:0] op_c,
   output logic [2*P-1:0] sum_o
);

   if (P < 2) begin : g_bad_p
      $error("sd3_mod_adder: P must be at least 2");
   end

   logic [2*P-1:0] u_vec, t_vec;

   sd3_csa #(.P(P), .MOD_PLUS(MOD_PLUS)) u_csa (
      .a_i (op_a),
      .b_i (op_b),
      .c_i (op_c),
      .u_o (u_vec),
      .t_o (t_vec)
   );

   sd3_mod_add2 #(.P(P), .MOD_PLUS(MOD_PLUS)) u_add2 (
      .x_i (u_vec),
      .y_i (t_vec),
      .s_o (sum_o)
   );

   for (genvar i = 0; i < P; i++) begin : g_code
      always_comb begin
         if (!$isunknown({op_a, op_b, op_c}))
            a_r3_no_code11: assert (sum_o[2*i +: 2] != 2'b11)
               else $error("result digit %0d has code 11", i);
      end
   end

   always_comb begin
      if ((op_a == '0) && (op_b == '0) && (op_c == '0))
         a_r4_zero_in_zero_out: assert (sum_o == '0)
            else $error("zero operands gave nonzero result");
   end

endmodule

// File: tb/sd3_mod_adder_test.sv
module sd3_mod_adder_test;

   localparam int P = 8;
   localparam int MM = (1 << P) - 1;
   localparam int MP = (1 << P) + 1;

   typedef struct {
      int    exp_m;
      int    exp_p;
      string tag_m;
      string tag_p;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2*P-1:0] a = '0, b = '0, c = '0;
   logic [2*P-1:0] sum_m, sum_p;

   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sd3_mod_adder #(.P(P), .MOD_PLUS(1'b0)) uut (
      .op_a(a), .op_b(b), .op_c(c), .sum_o(sum_m));

   sd3_mod_adder #(.P(P), .MOD_PLUS(1'b1)) uut_plus (
      .op_a(a), .op_b(b), .op_c(c), .sum_o(sum_p));

   function automatic int dec(logic [2*P-1:0] v);
      int acc = 0;
      for (int i = 0; i < P; i++)
         acc += (int'(v[2*i+1]) - int'(v[2*i])) * (1 << i);
      return acc;
   endfunction

   function automatic int md(int x, int m);
      return ((x % m) + m) % m;
   endfunction

   function automatic bit has11(logic [2*P-1:0] v);
      for (int i = 0; i < P; i++)
         if (v[2*i +: 2] == 2'b11) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [2*P-1:0] fill(logic [1:0] code);
      logic [2*P-1:0] r;
      for (int i = 0; i < P; i++) r[2*i +: 2] = code;
      return r;
   endfunction

   function automatic logic [2*P-1:0] rnd_sd();
      logic [2*P-1:0] r;
      for (int i = 0; i < P; i++) begin
         case ($urandom_range(0, 2))
            0:       r[2*i +: 2] = 2'b00;
            1:       r[2*i +: 2] = 2'b10;
            default: r[2*i +: 2] = 2'b01;
         endcase
      end
      return r;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(logic [2*P-1:0] va, logic [2*P-1:0] vb, logic [2*P-1:0] vc,
                        string tm, string tp);
      item_t it;
      int tot;
      @(posedge clk);
      #1;
      a = va; b = vb; c = vc;
      tot = dec(va) + dec(vb) + dec(vc);
      it.exp_m = md(tot, MM);
      it.exp_p = md(tot, MP);
      it.tag_m = tm;
      it.tag_p = tp;
      q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(md(dec(sum_m), MM) == it.exp_m, it.tag_m, md(dec(sum_m), MM), it.exp_m);
         check(md(dec(sum_p), MP) == it.exp_p, it.tag_p, md(dec(sum_p), MP), it.exp_p);
         check(!has11(sum_m) && !has11(sum_p), "R3", int'(has11(sum_m) | has11(sum_p)), 0);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      logic [2*P-1:0] top_p, top_n;
      top_p = '0; top_p[2*(P-1)+1] = 1'b1;
      top_n = '0; top_n[2*(P-1)]   = 1'b1;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R4: zero operands give an all-zero result, checked at the ports
      @(negedge clk);
      check(sum_m == '0, "R4", int'(sum_m), 0);
      check(sum_p == '0, "R4", int'(sum_p), 0);

      // R5 / R6: top-digit transfers wrap into digit 0
      drive(top_p, top_p, top_p, "R5", "R6");
      drive(top_n, top_n, top_n, "R5", "R6");
      drive(top_p, top_p, '0,    "R5", "R6");
      drive(top_p | fill(2'b10) & {{2{1'b0}}, {(2*P-2){1'b1}}}, top_p, top_p, "R5", "R6");
      drive(top_n | fill(2'b01) & {{2{1'b0}}, {(2*P-2){1'b1}}}, top_n, top_n, "R5", "R6");

      // R7: extreme operands
      drive(fill(2'b10), fill(2'b10), fill(2'b10), "R7", "R7");
      drive(fill(2'b01), fill(2'b01), fill(2'b01), "R7", "R7");
      drive(fill(2'b10), fill(2'b01), fill(2'b10), "R7", "R7");
      drive(fill(2'b01), fill(2'b01), fill(2'b10), "R7", "R7");

      // R1 / R2: random signed-digit operands
      for (int n = 0; n < 400; n++)
         drive(rnd_sd(), rnd_sd(), rnd_sd(), "R1", "R2");

      drive('0, '0, '0, "R4", "R4");
      repeat (4) @(posedge clk);
      finish_run();
   end

   initial begin
      #100000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
      finish_run();
   end

endmodule